// File: doc/BRIEF.md
# Alarm RAM Digit Comparator

This block keeps a small user RAM, laid out nibble for nibble like the live time-of-day counter. Every nibble is compared with the counter digit in the same position. A single alarm flag is raised when every compared digit agrees. The RAM serves as an alarm setting, or as general scratch storage. A host reaches it over a byte interface, with two digits in each byte.

The counter sits outside this block. It supplies all sixteen of its nibble positions as one parallel bus. Counter addresses 0 to 7 each carry a low (units) and a high (tens) nibble, so position `2*a` is the low nibble of address `a` and position `2*a+1` is the high nibble. Two of those positions hold no real digit and are never compared: position 0 (the low nibble of address 0) and position 11 (the high nibble of address 5). The RAM therefore stores only the other fourteen nibbles, 56 bits in all.

A nibble whose two upper bits are both set acts as a wildcard. Counter bits that a BCD digit cannot use are taken as zero before the compare. The result is registered, so that the downstream interrupt logic never sees a glitch while counter digits settle.

Top module: `alarm_cmp_top`

## Requirements
- R1: While reset is held, `alarm_match` is 0. After reset, every RAM nibble reads 0.
- R2: A write to address `8+a` (a = 0..7) stores `bus_wdata[3:0]` into position `2*a` and `bus_wdata[7:4]` into position `2*a+1`. Reading that address while `bus_wr` is low returns both nibbles at the same bit places, and all four bits of every stored nibble are kept.
- R3: Positions 0 and 11 have no storage. Reading address 08h returns 0 in bits [3:0], reading address 0Dh returns 0 in bits [7:4], and writes to those nibbles have no effect.
- R4: Addresses 00h to 07h are outside the RAM. A write there changes no stored nibble, and a read there returns 8'h00.
- R5: When every compared counter digit, with its unused bits cleared, equals the stored nibble, `alarm_match` is 1.
- R6: If any single compared digit differs from its stored nibble, `alarm_match` is 0.
- R7: A stored nibble with bits [3:2] = 2'b11 matches any counter value in its position.
- R8: Counter bits outside each digit's range are taken as zero. The used bits per position are:
  - positions 1–4, 6, 8, 12 and 14: 4 bits;
  - positions 5, 7 and 10: 3 bits;
  - positions 9 and 13: 2 bits;
  - position 15: 1 bit.
  So a set counter bit in an unused place does not break a match, and a stored 1 in an unused place prevents a match unless the nibble is a wildcard.
- R9: Counter positions 0 and 11 have no effect on `alarm_match`.
- R10: `alarm_match` changes only on a clock edge. It shows the compare of the counter and RAM values present before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Byte address; 08h to 0Fh select the RAM |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_wdata | input | 8 | Write data, high nibble = odd position |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| cnt_digits | input | 64 | Live counter, nibble `p` at bits `[4p+3:4p]` |
| alarm_match | output | 1 | Registered all-digits-agree flag |

## Verification
Two kinds of internal fault reach the ports in different ways:
- A corrupted or misplaced RAM nibble shows on `bus_rdata` in the same cycle that its byte address is presented.
- A wrong mask, wildcard decode or position mapping changes nothing on the read side. It appears on `alarm_match` exactly one edge after a counter pattern that exercises that digit.

The directed patterns therefore set the following, one at a time, and sample the flag after one edge:
- each skipped position;
- each masked bit;
- a wildcard nibble;
- a single mismatching digit.

// File: rtl/alarm_cmp_pkg.sv
// Package alarm_cmp_pkg
// Shared constants and per-position digit attributes for the alarm
// comparator. Assumes the counter exposes 16 nibble positions, two per
// byte address, low nibble first.
package alarm_cmp_pkg;
    localparam int DIGIT_W  = 4;
    localparam int NUM_POS  = 16;
    localparam int SKIP_LO  = 0;
    localparam int SKIP_HI  = 11;
    localparam int NUM_ROWS = NUM_POS / 2;
    localparam int BYTE_W   = 2 * DIGIT_W;

    // Bits a BCD digit at this counter position can actually use.
    function automatic logic [DIGIT_W-1:0] used_bits(input int pos);
        case (pos)
            1, 2, 3, 4, 6, 8, 12, 14: used_bits = 4'hF;
            5, 7, 10:                 used_bits = 4'h7;
            9, 13:                    used_bits = 4'h3;
            15:                       used_bits = 4'h1;
            default:                  used_bits = 4'h0;
        endcase
    endfunction

    // True for positions that take part in the compare and own storage.
    function automatic bit is_compared(input int pos);
        is_compared = (pos != SKIP_LO) && (pos != SKIP_HI);
    endfunction
endpackage

// File: rtl/alarm_ram_bank.sv
// Module alarm_ram_bank
// Byte-addressed nibble storage laid out like the counter. Only compared
// positions own a register; skipped positions read as zero. Assumes one
// write per cycle and a combinational read path.
module alarm_ram_bank
    import alarm_cmp_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int RAM_BASE = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_wr,
    input  logic [BYTE_W-1:0]          bus_wdata,
    output logic [BYTE_W-1:0]          bus_rdata,
    output logic [NUM_POS*DIGIT_W-1:0] ram_nibbles
);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(RAM_BASE);
    localparam logic [ADDR_W-1:0] ROWS_A = ADDR_W'(NUM_ROWS);

    logic [ADDR_W-1:0]  row_off;
    logic               hit;
    logic [DIGIT_W-1:0] ram_q [NUM_POS];
    logic [BYTE_W-1:0]  row_keep;

    // Decode whether the address falls in the RAM window.
    always_comb begin
        row_off = bus_addr - BASE_A;
        hit     = (bus_addr >= BASE_A) && (row_off < ROWS_A);
    end

    for (genvar p = 0; p < NUM_POS; p++) begin : g_pos
        if (is_compared(p)) begin : g_store
            // Capture this position's nibble when its row is written.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    ram_q[p] <= '0;
                else if (bus_wr && hit && (row_off == ADDR_W'(p / 2)))
                    ram_q[p] <= bus_wdata[(p % 2)*DIGIT_W +: DIGIT_W];
            end
        end else begin : g_absent
            assign ram_q[p] = '0;
        end
        assign ram_nibbles[p*DIGIT_W +: DIGIT_W] = ram_q[p];
    end

    // Select the addressed row onto the read bus; zero outside the window.
    always_comb begin
        bus_rdata = '0;
        row_keep  = '0;
        for (int r = 0; r < NUM_ROWS; r++) begin
            if (hit && (row_off == ADDR_W'(r))) begin
                bus_rdata = {ram_q[2*r+1], ram_q[2*r]};
                row_keep  = {{DIGIT_W{is_compared(2*r+1)}}, {DIGIT_W{is_compared(2*r)}}};
            end
        end
    end

    // A write in the window reads back next cycle at the same address.
    assert_wr_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit) |=> ((bus_addr != $past(bus_addr)) ||
                             (bus_rdata == $past(bus_wdata & row_keep))));

    // A write outside the window leaves the storage unchanged.
    assert_outside_wr_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !hit) |=> $stable(ram_nibbles));
endmodule

// File: rtl/alarm_digit_cmp.sv
// Module alarm_digit_cmp
// Per-position comparator. A stored nibble with its two top bits set is a
// wildcard; otherwise it must equal the counter digit with unused bits
// cleared. Skipped positions always agree. Purely combinational.
module alarm_digit_cmp
    import alarm_cmp_pkg::*;
(
    input  logic [NUM_POS*DIGIT_W-1:0] ram_nibbles,
    input  logic [NUM_POS*DIGIT_W-1:0] cnt_digits,
    output logic                       all_agree
);
    logic [NUM_POS-1:0] agree;

    for (genvar p = 0; p < NUM_POS; p++) begin : g_cmp
        if (is_compared(p)) begin : g_live
            logic [DIGIT_W-1:0] stored;
            logic [DIGIT_W-1:0] live;
            // Mask the counter digit and test it against the stored nibble.
            always_comb begin
                stored   = ram_nibbles[p*DIGIT_W +: DIGIT_W];
                live     = cnt_digits[p*DIGIT_W +: DIGIT_W] & used_bits(p);
                agree[p] = (stored[DIGIT_W-1 -: 2] == 2'b11) || (stored == live);
            end
        end else begin : g_skip
            assign agree[p] = 1'b1;
        end
    end

    // Combine all position results.
    assign all_agree = &agree;
endmodule

// File: rtl/alarm_cmp_top.sv
// Module alarm_cmp_top
// Alarm RAM plus digit comparator with a registered match flag. Assumes the
// counter bus is synchronous to clk; the flag lags its inputs by one edge so
// digit ripple never reaches the interrupt logic.
module alarm_cmp_top
    import alarm_cmp_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int RAM_BASE = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_wr,
    input  logic [BYTE_W-1:0]          bus_wdata,
    output logic [BYTE_W-1:0]          bus_rdata,
    input  logic [NUM_POS*DIGIT_W-1:0] cnt_digits,
    output logic                       alarm_match
);
    logic [NUM_POS*DIGIT_W-1:0] ram_nibbles;
    logic                       all_agree;
    logic                       all_wild;

    alarm_ram_bank #(.ADDR_W(ADDR_W), .RAM_BASE(RAM_BASE)) ram_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .ram_nibbles(ram_nibbles)
    );

    alarm_digit_cmp cmp_i (
        .ram_nibbles(ram_nibbles),
        .cnt_digits (cnt_digits),
        .all_agree  (all_agree)
    );

    // Register the compare result for a glitch-free flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            alarm_match <= 1'b0;
        else
            alarm_match <= all_agree;
    end

    // Assertion helper: every stored nibble is a wildcard.
    always_comb begin
        all_wild = 1'b1;
        for (int p = 0; p < NUM_POS; p++)
            if (is_compared(p) && (ram_nibbles[p*DIGIT_W+2 +: 2] != 2'b11))
                all_wild = 1'b0;
    end

    // A RAM made of wildcards matches whatever the counter shows.
    assert_all_wild_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        all_wild |=> alarm_match);

    // With counter and RAM held steady, the flag does not move.
    assert_flag_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(cnt_digits) && !bus_wr && !$past(bus_wr))
            |=> $stable(alarm_match));
endmodule

// File: tb/alarm_cmp_top_tb_top.sv
// Directed bench for alarm_cmp_top: one task per scenario, each checking
// its own results. Inputs change on the falling edge; outputs are sampled
// off the rising edge.
module alarm_cmp_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [63:0] cnt_digits = '0;
    logic        alarm_match;

    int n_chk = 0;
    int n_bad = 0;

    // Reference time image: one byte per counter address 0..7.
    logic [7:0] img [8] = '{8'h30, 8'h45, 8'h42, 8'h15, 8'h10, 8'h03, 8'h27, 8'h11};

    always #4 clk = ~clk;

    alarm_cmp_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt_digits(cnt_digits), .alarm_match(alarm_match)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1 check(req, bus_rdata, exp);
    endtask

    // Flag after the next rising edge.
    task automatic match_chk(input string req, input logic exp);
        @(posedge clk); #1;
        check(req, {7'd0, alarm_match}, {7'd0, exp});
    endtask

    task automatic set_cnt_byte(input int a, input logic [7:0] v);
        @(negedge clk);
        cnt_digits[8*a +: 8] = v;
    endtask

    task automatic load_image();
        for (int a = 0; a < 8; a++) begin
            cnt_digits[8*a +: 8] = img[a];
            wr(4'(8 + a), img[a]);
        end
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        #1 check("R1 flag in reset", {7'd0, alarm_match}, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        for (int a = 8; a < 16; a++) rd_chk("R1 ram cleared", 4'(a), 8'h00);
    endtask

    task automatic t_readback();
        load_image();
        rd_chk("R2 readback 0Ah", 4'hA, 8'h42);
        wr(4'hC, 8'hA5);
        rd_chk("R2 all bits kept", 4'hC, 8'hA5);
        wr(4'hC, img[4]);
        rd_chk("R2 restore 0Ch", 4'hC, 8'h10);
    endtask

    task automatic t_absent();
        wr(4'h8, 8'hFF);
        rd_chk("R3 pos0 absent", 4'h8, 8'hF0);
        wr(4'hD, 8'hFF);
        rd_chk("R3 pos11 absent", 4'hD, 8'h0F);
        wr(4'h8, img[0]);
        wr(4'hD, img[5]);
    endtask

    task automatic t_outside();
        wr(4'h3, 8'hFF);
        rd_chk("R4 ram untouched", 4'hB, 8'h15);
        rd_chk("R4 outside reads 0", 4'h3, 8'h00);
    endtask

    task automatic t_match_miss();
        match_chk("R5 full match", 1'b1);
        set_cnt_byte(2, 8'h43);
        match_chk("R6 seconds differ", 1'b0);
        set_cnt_byte(2, 8'h42);
        set_cnt_byte(7, 8'h01);
        match_chk("R6 month tens differ", 1'b0);
        set_cnt_byte(7, img[7]);
        match_chk("R5 match restored", 1'b1);
    endtask

    task automatic t_wildcard();
        set_cnt_byte(2, 8'h49);
        wr(4'hA, 8'h4C);
        match_chk("R7 wildcard units", 1'b1);
        wr(4'hA, 8'hC2);
        match_chk("R7 top bits not tens 4", 1'b0);
        wr(4'hA, 8'h42);
        set_cnt_byte(2, 8'h42);
    endtask

    task automatic t_unused();
        set_cnt_byte(7, 8'hF1);
        match_chk("R8 month tens masked", 1'b1);
        set_cnt_byte(2, 8'hC2);
        match_chk("R8 seconds tens masked", 1'b1);
        wr(4'hF, 8'h31);
        match_chk("R8 stored unused bit", 1'b0);
        wr(4'hF, img[7]);
        set_cnt_byte(7, img[7]);
        set_cnt_byte(2, img[2]);
    endtask

    task automatic t_skipped();
        set_cnt_byte(0, 8'h3F);
        set_cnt_byte(5, 8'hF3);
        match_chk("R9 skipped positions", 1'b1);
        set_cnt_byte(0, 8'h2F);
        match_chk("R9 ms tens still compared", 1'b0);
        set_cnt_byte(0, img[0]);
        set_cnt_byte(5, img[5]);
    endtask

    task automatic t_latency();
        match_chk("R10 settle", 1'b1);
        @(negedge clk);
        cnt_digits[8*3 +: 8] = 8'h16;
        #1 check("R10 no change before edge", {7'd0, alarm_match}, 8'h01);
        match_chk("R10 change after edge", 1'b0);
        @(negedge clk);
        cnt_digits[8*3 +: 8] = img[3];
        #1 check("R10 held before edge", {7'd0, alarm_match}, 8'h00);
        match_chk("R10 back after edge", 1'b1);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_readback();
        t_absent();
        t_outside();
        t_match_miss();
        t_wildcard();
        t_unused();
        t_skipped();
        t_latency();
        finish_run();
    end
endmodule